// File: doc/BRIEF.md
# Multi-Mode Integer Multiply Stage

This block multiplies two 64-bit register operands for an integer execution pipeline. One datapath produces either half of the product, at either a 32-bit or a 64-bit operating width. A 2-bit operation code selects the high half of a 32-bit product, the high half of a 64-bit product, or the low half of a product. The flags `is_32bit` and `is_signed` qualify the operation. For the low-half forms the stage also reports an overflow flag, which is driven on two identical output bits.

The multiplier always works on unsigned magnitudes. Signed operands are first turned into their absolute value at the operating width. The magnitudes are multiplied. The product is then negated when the two operand signs differ.

The arithmetic is combinational. A single register stage captures it under `in_valid`, so the result appears one clock edge after it is presented.

Top module: `mulstage_top`

## Requirements
- R1: With `op_sel` = 0 (high half, 32-bit), the stage forms the 64-bit product of `opnd_a[31:0]` and `opnd_b[31:0]`, signed when `is_signed`=1 and unsigned otherwise. The result holds the upper 32 bits of that product in both `result[63:32]` and `result[31:0]`. Operand bits 63..32 and `is_32bit` have no effect.
- R2: With `op_sel` = 1 (high half, 64-bit), the result is bits 127..64 of the 128-bit product of the full operands, signed or unsigned per `is_signed`. `is_32bit` has no effect.
- R3: With `op_sel` = 2 and `is_32bit`=1, the result is the full 64-bit product of the low 32 bits of each operand, signed or unsigned per `is_signed`.
- R4: With `op_sel` = 2 and `is_32bit`=0, the result is bits 63..0 of the signed 128-bit product, whatever the value of `is_signed`.
- R5: Signed operation gives the exact product even when an operand is the most negative value at the operating width (0x80000000 at 32 bits, 0x8000000000000000 at 64 bits).
- R6: For `op_sel` = 2 with `is_32bit`=1, overflow is 1 exactly when product bits 63..31 are neither all zero nor all one. Both `ovf` bits carry this value.
- R7: For `op_sel` = 2 with `is_32bit`=0, overflow is 1 exactly when signed product bits 127..63 are neither all zero nor all one. Both `ovf` bits carry this value.
- R8: For `op_sel` = 0 and `op_sel` = 1, `ovf` is 00.
- R9: `op_sel` = 3 is unused. It yields a zero result and `ovf` = 00.
- R10: While `rst_n` is low, `out_valid`, `result` and `ovf` are zero. After each rising edge `out_valid` equals the `in_valid` value sampled at that edge. `result` and `ovf` load only on edges where `in_valid`=1 and hold their value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| op_sel | input | 2 | 0 high-32, 1 high-64, 2 low, 3 unused |
| is_32bit | input | 1 | Selects 32-bit width for the low operation |
| is_signed | input | 1 | Treat operands as signed |
| opnd_a | input | 64 | First operand |
| opnd_b | input | 64 | Second operand |
| out_valid | output | 1 | Registered result is valid |
| result | output | 64 | Registered product half |
| ovf | output | 2 | Registered overflow flag, both bits equal |

## Verification
Each operation is driven with random operands and with the corner values 0, 1, -1 and the most negative and most positive numbers at its width. Mixed signs separate a correct sign correction from a missing one. Most-negative operands expose a magnitude step that wraps. Operands whose upper 32 bits are junk show whether the 32-bit forms really ignore them.

The expected values come from the language's own signed and unsigned multiply, not from the magnitude method used in the design. Products that land just inside and just outside the low-half range distinguish the overflow window from an off-by-one bit range. Cycles with `in_valid` low and changed operands confirm that the registered outputs hold.

// File: rtl/mulstage_pkg.sv
package mulstage_pkg;
  typedef enum logic [1:0] {
    MOP_HI_HALF = 2'd0,
    MOP_HI_FULL = 2'd1,
    MOP_LOW     = 2'd2,
    MOP_NONE    = 2'd3
  } mop_e;

  typedef struct packed {
    logic narrow;     // operate on the low half of each operand
    logic signed_op;  // apply sign handling
  } mctl_t;
endpackage

// File: rtl/mul_decode.sv
module mul_decode
  import mulstage_pkg::*;
(
  input  mop_e  op,
  input  logic  is_32bit,
  input  logic  is_signed,
  output mctl_t ctl
);
  // High-32 is always narrow; high-64 always wide; low follows is_32bit.
  // The wide low form exists only as a signed operation.
  always_comb begin
    ctl.narrow    = (op == MOP_HI_HALF) || ((op == MOP_LOW) && is_32bit);
    ctl.signed_op = is_signed || ((op == MOP_LOW) && !is_32bit);
  end
endmodule

// File: rtl/mul_mag.sv
module mul_mag #(
  parameter int W = 64
) (
  input  logic [W-1:0] x,
  input  logic         narrow,
  input  logic         signed_op,
  output logic [W-1:0] mag,
  output logic         neg
);
  localparam int H = W / 2;

  // Two's complement negate at the chosen width; the upper half is cleared
  // at narrow width. The most negative value maps to its own bit pattern,
  // which read unsigned is the correct magnitude.
  function automatic logic [W-1:0] negate_at(input logic [W-1:0] v, input logic nar);
    logic [W-1:0] n;
    n = ~v + {{(W-1){1'b0}}, 1'b1};
    if (nar) n[W-1:H] = '0;
    return n;
  endfunction

  logic [W-1:0] raw;
  logic         sign_bit;

  always_comb begin
    raw      = narrow ? {{H{1'b0}}, x[H-1:0]} : x;
    sign_bit = narrow ? x[H-1] : x[W-1];
    neg      = signed_op && sign_bit;
    mag      = neg ? negate_at(raw, narrow) : raw;
  end
endmodule

// File: rtl/mul_core.sv
module mul_core #(
  parameter int W = 64
) (
  input  logic [W-1:0]   mag_a,
  input  logic [W-1:0]   mag_b,
  input  logic           neg_a,
  input  logic           neg_b,
  output logic [2*W-1:0] prod,
  output logic           flip
);
  localparam int PW = 2 * W;

  function automatic logic [PW-1:0] umul(input logic [W-1:0] p, input logic [W-1:0] q);
    logic [PW-1:0] pe, qe;
    pe = {{W{1'b0}}, p};
    qe = {{W{1'b0}}, q};
    return pe * qe;
  endfunction

  logic [PW-1:0] uprod;

  always_comb begin
    uprod = umul(mag_a, mag_b);
    flip  = neg_a ^ neg_b;           // signs differ: product is negative
    prod  = flip ? (~uprod + {{(PW-1){1'b0}}, 1'b1}) : uprod;
  end
endmodule

// File: rtl/mul_pick.sv
module mul_pick
  import mulstage_pkg::*;
#(
  parameter int W = 64
) (
  input  mop_e           op,
  input  logic           narrow,
  input  logic [2*W-1:0] prod,
  output logic [W-1:0]   res,
  output logic           ov_flag
);
  localparam int H = W / 2;

  // Overflow when the window is neither all zeros nor all ones.
  function automatic logic mixed_bits(input logic [W+1:0] v, input int n);
    logic any1, all1;
    any1 = 1'b0;
    all1 = 1'b1;
    for (int i = 0; i < W + 2; i++) begin
      if (i < n) begin
        any1 = any1 | v[i];
        all1 = all1 & v[i];
      end
    end
    return any1 & ~all1;
  endfunction

  logic [W+1:0] win_narrow, win_wide;

  always_comb begin
    win_narrow = {{(H+1){1'b0}}, prod[W-1:H-1]};  // H+1 bits used
    win_wide   = {1'b0, prod[2*W-1:W-1]};         // W+1 bits used
    res        = '0;
    ov_flag    = 1'b0;
    case (op)
      MOP_HI_HALF: res = {prod[W-1:H], prod[W-1:H]};
      MOP_HI_FULL: res = prod[2*W-1:W];
      MOP_LOW: begin
        res     = prod[W-1:0];
        ov_flag = narrow ? mixed_bits(win_narrow, H + 1) : mixed_bits(win_wide, W + 1);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mulstage_top.sv
module mulstage_top
  import mulstage_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int OV_REP = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [1:0]      op_sel,
  input  logic            is_32bit,
  input  logic            is_signed,
  input  logic [XLEN-1:0] opnd_a,
  input  logic [XLEN-1:0] opnd_b,
  output logic            out_valid,
  output logic [XLEN-1:0] result,
  output logic [OV_REP-1:0] ovf
);
  localparam int HALF = XLEN / 2;

  mop_e  op;
  mctl_t ctl;
  assign op = mop_e'(op_sel);

  mul_decode u_dec (.op(op), .is_32bit(is_32bit), .is_signed(is_signed), .ctl(ctl));

  logic [XLEN-1:0] opnds [2];
  logic [XLEN-1:0] mags  [2];
  logic            negs  [2];
  assign opnds[0] = opnd_a;
  assign opnds[1] = opnd_b;

  for (genvar g = 0; g < 2; g++) begin : g_mag
    mul_mag #(.W(XLEN)) u_mag (
      .x(opnds[g]), .narrow(ctl.narrow), .signed_op(ctl.signed_op),
      .mag(mags[g]), .neg(negs[g])
    );
  end

  logic [2*XLEN-1:0] prod;
  logic              sign_flip;
  mul_core #(.W(XLEN)) u_core (
    .mag_a(mags[0]), .mag_b(mags[1]), .neg_a(negs[0]), .neg_b(negs[1]),
    .prod(prod), .flip(sign_flip)
  );

  logic [XLEN-1:0] res_c;
  logic            ov_c;
  mul_pick #(.W(XLEN)) u_pick (
    .op(op), .narrow(ctl.narrow), .prod(prod), .res(res_c), .ov_flag(ov_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      ovf       <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= res_c;
        ovf    <= {OV_REP{ov_c}};
      end
    end
  end

  AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid) else $error("valid not forwarded"); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result) && $stable(ovf))) else $error("output moved while idle"); // R10
  AST_HI_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op_sel == 2'd0 || op_sel == 2'd1)) |=> (ovf == '0)) else $error("overflow on high op"); // R8
  AST_HI32_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 2'd0) |=> (result[XLEN-1:HALF] == result[HALF-1:0])) else $error("high words differ"); // R1
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 2'd3) |=> (result == '0 && ovf == '0)) else $error("unused op not zero"); // R9
  AST_ZERO_OPND: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opnd_a == '0) |=> (result == '0 && ovf == '0)) else $error("zero operand product"); // R3
  AST_SIGN_SAME_POS: assert property (@(posedge clk) disable iff (!rst_n)
    (!sign_flip || prod == '0 || prod[2*XLEN-1])) else $error("negative product sign lost"); // R5
endmodule

// File: tb/test_mulstage_top.sv
module test_mulstage_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  op_sel = 2'd0;
  logic        is_32bit = 1'b0;
  logic        is_signed = 1'b0;
  logic [63:0] opnd_a = '0;
  logic [63:0] opnd_b = '0;
  logic        out_valid;
  logic [63:0] result;
  logic [1:0]  ovf;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  mulstage_top i_mulstage_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .is_32bit(is_32bit), .is_signed(is_signed), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .out_valid(out_valid), .result(result), .ovf(ovf)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference built on the language's own multiply.
  task automatic model(input logic [1:0] op, input logic w32, input logic sg,
                       input logic [63:0] a, input logic [63:0] b,
                       output logic [63:0] res, output logic [1:0] ov);
    logic signed [63:0]  s64;
    logic [63:0]         u64;
    logic signed [127:0] s128;
    logic [127:0]        u128;
    logic [63:0]         p;
    res = '0; ov = 2'b00;
    s64  = $signed({{32{a[31]}}, a[31:0]}) * $signed({{32{b[31]}}, b[31:0]});
    u64  = {32'b0, a[31:0]} * {32'b0, b[31:0]};
    s128 = $signed({{64{a[63]}}, a}) * $signed({{64{b[63]}}, b});
    u128 = {64'b0, a} * {64'b0, b};
    case (op)
      2'd0: begin p = sg ? s64 : u64; res = {p[63:32], p[63:32]}; end
      2'd1: res = sg ? s128[127:64] : u128[127:64];
      2'd2: if (w32) begin
              p = sg ? s64 : u64;
              res = p;
              ov = (p != {{32{p[31]}}, p[31:0]}) ? 2'b11 : 2'b00;
            end else begin
              res = s128[63:0];
              ov = (s128 != {{64{s128[63]}}, s128[63:0]}) ? 2'b11 : 2'b00;
            end
      default: ;
    endcase
  endtask

  task automatic run(input string req, input logic [1:0] op, input logic w32,
                     input logic sg, input logic [63:0] a, input logic [63:0] b);
    logic [63:0] er;
    logic [1:0]  eo;
    model(op, w32, sg, a, b, er, eo);
    @(negedge clk);
    in_valid = 1'b1; op_sel = op; is_32bit = w32; is_signed = sg;
    opnd_a = a; opnd_b = b;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, {63'b0, out_valid}, 64'd1);
    check({req, " result"}, result, er);
    check({req, " ovf"}, {62'b0, ovf}, {62'b0, eo});
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  task automatic t_reset();
    check("R10 reset valid", {63'b0, out_valid}, 64'd0);
    check("R10 reset result", result, 64'd0);
    check("R10 reset ovf", {62'b0, ovf}, 64'd0);
  endtask

  task automatic t_hi32();
    run("R1 unsigned", 2'd0, 1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
    run("R1 signed mixed", 2'd0, 1'b1, 1'b1, 64'h0000_0000_FFFF_FFFE, 64'h0000_0000_0000_0003);
    run("R1 junk upper", 2'd0, 1'b0, 1'b1, 64'hDEAD_BEEF_8000_0000, 64'h1234_5678_7FFF_FFFF);
    for (int i = 0; i < 20; i++) begin
      run("R1 random", 2'd0, 1'b1, i[0], rnd64(), rnd64());
      run("R8 high32 no ovf", 2'd0, 1'b1, 1'b1, rnd64(), rnd64());
    end
  endtask

  task automatic t_hi64();
    run("R2 unsigned max", 2'd1, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
    run("R2 signed -1", 2'd1, 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd5);
    run("R2 is_32bit ignored", 2'd1, 1'b1, 1'b1, 64'h8000_0000_0000_0001, 64'h7FFF_FFFF_FFFF_FFFF);
    for (int i = 0; i < 20; i++) begin
      run("R2 random", 2'd1, 1'b0, i[0], rnd64(), rnd64());
      run("R8 high64 no ovf", 2'd1, 1'b0, 1'b0, rnd64(), rnd64());
    end
  endtask

  task automatic t_lo32();
    run("R3 unsigned", 2'd2, 1'b1, 1'b0, 64'hAAAA_0000_FFFF_FFFF, 64'h5555_0000_0000_0002);
    run("R3 signed neg", 2'd2, 1'b1, 1'b1, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0007);
    run("R6 edge in range", 2'd2, 1'b1, 1'b1, 64'h0000_0000_0000_4000, 64'h0000_0000_FFFE_0000);
    run("R6 edge out of range", 2'd2, 1'b1, 1'b1, 64'h0000_0000_0000_8000, 64'h0000_0000_0001_0000);
    run("R6 unsigned small", 2'd2, 1'b1, 1'b0, 64'd3, 64'd5);
    for (int i = 0; i < 20; i++) run("R6 random", 2'd2, 1'b1, i[0], rnd64(), rnd64());
  endtask

  task automatic t_lo64();
    run("R4 signed", 2'd2, 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFD, 64'd9);
    run("R4 is_signed ignored", 2'd2, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFD, 64'd9);
    run("R7 edge in range", 2'd2, 1'b0, 1'b1, 64'h0000_0000_4000_0000, 64'hFFFF_FFFE_0000_0000);
    run("R7 edge out of range", 2'd2, 1'b0, 1'b1, 64'h0000_0000_8000_0000, 64'h0000_0001_0000_0000);
    for (int i = 0; i < 20; i++) run("R7 random", 2'd2, 1'b0, i[0], rnd64(), rnd64());
  endtask

  task automatic t_corners();
    logic [63:0] c32 [5];
    logic [63:0] c64 [5];
    c32 = '{64'd0, 64'd1, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_8000_0000, 64'h0000_0000_7FFF_FFFF};
    c64 = '{64'd0, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF};
    for (int i = 0; i < 5; i++) begin
      for (int j = 0; j < 5; j++) begin
        run("R5 corner hi32", 2'd0, 1'b1, 1'b1, c32[i], c32[j]);
        run("R5 corner lo32", 2'd2, 1'b1, 1'b1, c32[i], c32[j]);
        run("R5 corner hi64", 2'd1, 1'b0, 1'b1, c64[i], c64[j]);
        run("R5 corner lo64", 2'd2, 1'b0, 1'b1, c64[i], c64[j]);
        run("R5 corner hi64u", 2'd1, 1'b0, 1'b0, c64[i], c64[j]);
      end
    end
  endtask

  task automatic t_unused();
    run("R9 unused op", 2'd3, 1'b0, 1'b1, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000);
    run("R9 unused op 32", 2'd3, 1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2);
  endtask

  task automatic t_hold();
    logic [63:0] keep;
    run("R10 load", 2'd2, 1'b1, 1'b1, 64'h0000_0000_8000_0000, 64'h0000_0000_0001_0000);
    keep = result;
    @(negedge clk);
    in_valid = 1'b0; op_sel = 2'd1; opnd_a = 64'h1111; opnd_b = 64'h2222;
    @(negedge clk);
    check("R10 idle valid", {63'b0, out_valid}, 64'd0);
    check("R10 idle result held", result, keep);
    check("R10 idle ovf held", {62'b0, ovf}, 64'd3);
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_hi32();
    t_hi64();
    t_lo32();
    t_lo64();
    t_corners();
    t_unused();
    t_hold();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule